// File: doc/BRIEF.md
# Fence-Ordered Store Buffer

This block holds retired stores between the core and the data cache and applies three kinds of memory fence to them. Stores arrive in program order, each marked normal or non-temporal. A fence arrives on its own input with a two-bit kind code. Stores leave one at a time on a commit port that the cache acknowledges. Loads ask to issue through a request/grant gate. The block counts how many granted loads have not yet completed.

A store fence does not drain the buffer. Every entry in the buffer carries an epoch number. A store fence or a full fence moves the current epoch forward, but only if the newest buffered entry belongs to the current epoch. The commit logic only looks at entries in the same epoch as the oldest entry. Inside that epoch, normal stores leave in arrival order, and the oldest non-temporal store may leave ahead of them. A load fence holds new loads back until all earlier loads have completed. A full fence holds new loads back until the buffer is empty.

Top module: `fence_store_buffer`

## Requirements
- R1: Reset state. After reset the buffer is empty, so `cm_valid`=0 and `st_ready`=1. `ld_outstanding`=0, and the load gate is open (`ld_req`=1 gives `ld_gnt`=1 in the same cycle).
- R2: Normal stores (`st_nt`=0) in one epoch reach the commit port in the order they were accepted.
- R3: Within the oldest epoch, the commit port offers the oldest non-temporal store (`st_nt`=1) in preference to an older normal store. This applies only when no offer is currently being held.
- R4: A store fence (`fence_kind`=2'b01) never deasserts `st_ready` and never withholds `ld_gnt`. A store accepted after the fence commits only after every store accepted before it, even when the later store is non-temporal.
- R5: A load fence (`fence_kind`=2'b10) withholds `ld_gnt` while any granted load is incomplete. This includes a request in the fence's own cycle. The gate opens in the cycle after the count reaches zero. Store acceptance and commit go on as normal during this time.
- R6: A full fence (`fence_kind`=2'b11) orders stores like a store fence. It also withholds `ld_gnt`, from its own cycle on, until the buffer is completely empty, including stores accepted after the fence.
- R7: A store fence followed by a load fence does not hold loads back on buffered stores. With no loads outstanding, `ld_gnt` is given while `cm_valid`=1.
- R8: A fence that arrives while the buffer is empty has no cost. A full fence on an empty buffer leaves `ld_gnt` available in its own cycle.
- R9: Once `cm_valid` is high, `cm_addr` and `cm_data` stay unchanged until `cm_ack`. This holds even if a younger non-temporal store arrives in the meantime.
- R10: With DEPTH entries held, `st_ready`=0. A store presented while the buffer is full is not taken in.
- R11: `ld_outstanding` goes up by one on each cycle with `ld_req`&&`ld_gnt`. It goes down by one on each `ld_done` while it is non-zero. No new grant is given at MAX_LOADS.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| st_valid | input | 1 | Store presented |
| st_ready | output | 1 | Buffer can accept a store |
| st_addr | input | AW | Store address |
| st_data | input | DW | Store data |
| st_nt | input | 1 | 1 = non-temporal store |
| fence_valid | input | 1 | Fence presented (treated as older than a store or load in the same cycle) |
| fence_kind | input | 2 | 01 store, 10 load, 11 full |
| ld_req | input | 1 | Load asks to issue |
| ld_gnt | output | 1 | Load may issue this cycle |
| ld_done | input | 1 | A granted load completed |
| ld_outstanding | output | LW | Granted, incomplete loads |
| cm_valid | output | 1 | Store offered to cache |
| cm_addr | output | AW | Offered store address |
| cm_data | output | DW | Offered store data |
| cm_ack | input | 1 | Cache took the offered store |

## Verification
The gate output `ld_gnt` is combinational. It reacts to a fence in the same cycle and to a released fence one clock edge after the last load completion or the last commit. The bench therefore samples it shortly after the falling edge, both before and after that release edge. `st_ready` and the commit offer change one edge after a push or an acknowledge, and `ld_outstanding` changes one edge after a grant or completion. Each check reads these values on the falling edge that follows that update, and stimulus is applied only on falling edges.

// File: rtl/fsb_pkg.sv
package fsb_pkg;

  typedef enum logic [1:0] {
    FK_NONE  = 2'b00,
    FK_STORE = 2'b01,
    FK_LOAD  = 2'b10,
    FK_FULL  = 2'b11
  } fence_kind_e;

  // A fence kind that orders stores against later stores.
  function automatic logic orders_stores(input logic [1:0] kind);
    return (kind == FK_STORE) || (kind == FK_FULL);
  endfunction

endpackage

// File: rtl/fsb_store_queue.sv
// Collapsing queue: slot 0 is the oldest entry; a removed slot is closed
// by shifting the younger slots down, new entries land at the tail.
module fsb_store_queue #(
  parameter int DEPTH = 8,
  parameter int AW    = 16,
  parameter int DW    = 32,
  parameter int EW    = 4
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          push,
  input  logic [AW-1:0]                 push_addr,
  input  logic [DW-1:0]                 push_data,
  input  logic                          push_nt,
  input  logic [EW-1:0]                 push_ep,
  input  logic                          pop,
  input  logic [$clog2(DEPTH)-1:0]      pop_idx,
  output logic [$clog2(DEPTH+1)-1:0]    cnt,
  output logic [$clog2(DEPTH+1)-1:0]    cnt_nx,
  output logic [DEPTH-1:0][AW-1:0]      addr_q,
  output logic [DEPTH-1:0][DW-1:0]      data_q,
  output logic [DEPTH-1:0]              nt_q,
  output logic [DEPTH-1:0][EW-1:0]      ep_q
);
  localparam int IW = $clog2(DEPTH);
  localparam int CW = $clog2(DEPTH+1);

  logic [CW-1:0]               cnt_q;
  logic [DEPTH-1:0][AW-1:0]    addr_n;
  logic [DEPTH-1:0][DW-1:0]    data_n;
  logic [DEPTH-1:0]            nt_n;
  logic [DEPTH-1:0][EW-1:0]    ep_n;
  logic [CW-1:0]               wr_pos;
  logic                        slots_en;

  always_comb begin
    addr_n = addr_q;
    data_n = data_q;
    nt_n   = nt_q;
    ep_n   = ep_q;
    if (pop) begin
      for (int i = 0; i < DEPTH-1; i++) begin
        if (IW'(i) >= pop_idx) begin
          addr_n[i] = addr_q[i+1];
          data_n[i] = data_q[i+1];
          nt_n[i]   = nt_q[i+1];
          ep_n[i]   = ep_q[i+1];
        end
      end
    end
    wr_pos = cnt_q - CW'(pop);
    if (push) begin
      addr_n[IW'(wr_pos)] = push_addr;
      data_n[IW'(wr_pos)] = push_data;
      nt_n[IW'(wr_pos)]   = push_nt;
      ep_n[IW'(wr_pos)]   = push_ep;
    end
    cnt_nx   = cnt_q + CW'(push) - CW'(pop);
    slots_en = push | pop;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_nx;
  end

  // Payload slots carry no reset; occupancy is defined by the count alone.
  always_ff @(posedge clk) begin
    if (slots_en) begin
      addr_q <= addr_n;
      data_q <= data_n;
      nt_q   <= nt_n;
      ep_q   <= ep_n;
    end
  end

  assign cnt = cnt_q;

endmodule

// File: rtl/fsb_commit_pick.sv
// Chooses which buffered store is offered to the cache and holds that
// choice until the cache acknowledges it.
module fsb_commit_pick #(
  parameter int DEPTH = 8,
  parameter int EW    = 4
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic [$clog2(DEPTH+1)-1:0]    cnt,
  input  logic [DEPTH-1:0]              nt_q,
  input  logic [DEPTH-1:0][EW-1:0]      ep_q,
  input  logic                          ack,
  output logic                          offer,
  output logic [$clog2(DEPTH)-1:0]      sel_idx
);
  localparam int IW = $clog2(DEPTH);
  localparam int CW = $clog2(DEPTH+1);

  logic          hold_q, hold_n;
  logic [IW-1:0] hold_idx_q, hold_idx_n;
  logic [IW-1:0] pick;
  logic          found;

  always_comb begin
    found = 1'b0;
    pick  = '0;
    for (int i = 0; i < DEPTH; i++) begin
      if (!found && (CW'(i) < cnt) && nt_q[i] && (ep_q[i] == ep_q[0])) begin
        pick  = IW'(i);
        found = 1'b1;
      end
    end
    offer      = (cnt != '0);
    sel_idx    = hold_q ? hold_idx_q : pick;
    hold_n     = offer & ~ack;
    hold_idx_n = sel_idx;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_q     <= 1'b0;
      hold_idx_q <= '0;
    end else begin
      hold_q     <= hold_n;
      hold_idx_q <= hold_idx_n;
    end
  end

endmodule

// File: rtl/fsb_load_gate.sv
// Load issue gate: outstanding-load counter plus load-fence and
// full-fence hold state.
module fsb_load_gate #(
  parameter int MAX_LOADS = 7
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            ld_req,
  input  logic                            ld_done,
  input  logic                            lf_now,
  input  logic                            ff_now,
  input  logic                            buf_empty,
  input  logic                            buf_empty_nx,
  output logic                            ld_gnt,
  output logic [$clog2(MAX_LOADS+1)-1:0]  ld_outstanding
);
  localparam int LW = $clog2(MAX_LOADS+1);

  logic [LW-1:0] out_q, out_n;
  logic          lf_pend_q, lf_pend_n;
  logic          ff_pend_q, ff_pend_n;
  logic          lf_arm, ff_arm, block, dec;

  always_comb begin
    lf_arm    = lf_now & (out_q != '0);
    ff_arm    = ff_now & ~buf_empty;
    block     = lf_pend_q | ff_pend_q | lf_arm | ff_arm | (out_q == LW'(MAX_LOADS));
    ld_gnt    = ld_req & ~block;
    dec       = ld_done & (out_q != '0);
    out_n     = out_q + LW'(ld_gnt) - LW'(dec);
    lf_pend_n = (lf_pend_q | lf_arm) & (out_n != '0);
    ff_pend_n = (ff_pend_q | ff_arm) & ~buf_empty_nx;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_q     <= '0;
      lf_pend_q <= 1'b0;
      ff_pend_q <= 1'b0;
    end else begin
      out_q     <= out_n;
      lf_pend_q <= lf_pend_n;
      ff_pend_q <= ff_pend_n;
    end
  end

  assign ld_outstanding = out_q;

endmodule

// File: rtl/fence_store_buffer.sv
module fence_store_buffer
  import fsb_pkg::*;
#(
  parameter int DEPTH     = 8,
  parameter int AW        = 16,
  parameter int DW        = 32,
  parameter int MAX_LOADS = 7
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            st_valid,
  output logic                            st_ready,
  input  logic [AW-1:0]                   st_addr,
  input  logic [DW-1:0]                   st_data,
  input  logic                            st_nt,
  input  logic                            fence_valid,
  input  logic [1:0]                      fence_kind,
  input  logic                            ld_req,
  output logic                            ld_gnt,
  input  logic                            ld_done,
  output logic [$clog2(MAX_LOADS+1)-1:0]  ld_outstanding,
  output logic                            cm_valid,
  output logic [AW-1:0]                   cm_addr,
  output logic [DW-1:0]                   cm_data,
  input  logic                            cm_ack
);
  localparam int IW = $clog2(DEPTH);
  localparam int CW = $clog2(DEPTH+1);
  // Live epochs span at most DEPTH values, so one spare bit avoids aliasing.
  localparam int EW = $clog2(DEPTH) + 1;
  localparam int LW = $clog2(MAX_LOADS+1);

  logic [CW-1:0]              buf_cnt, buf_cnt_nx;
  logic [DEPTH-1:0][AW-1:0]   addr_q;
  logic [DEPTH-1:0][DW-1:0]   data_q;
  logic [DEPTH-1:0]           nt_q;
  logic [DEPTH-1:0][EW-1:0]   ep_q;
  logic [IW-1:0]              sel_idx;
  logic [IW-1:0]              tail_idx;
  logic [EW-1:0]              cur_ep_q, cur_ep_n;
  logic                       push, pop, st_fence, adv, ep_en;
  logic                       lf_now, ff_now;

  always_comb begin
    st_ready = (buf_cnt != CW'(DEPTH));
    push     = st_valid & st_ready;
    pop      = cm_valid & cm_ack;
    st_fence = fence_valid & orders_stores(fence_kind);
    lf_now   = fence_valid & (fence_kind == FK_LOAD);
    ff_now   = fence_valid & (fence_kind == FK_FULL);
    tail_idx = IW'(buf_cnt - CW'(1));
    // Open a new epoch only if the newest entry sits in the current one:
    // fences on an empty buffer or back to back add no empty epoch.
    adv      = st_fence & (buf_cnt != '0) & (ep_q[tail_idx] == cur_ep_q);
    cur_ep_n = cur_ep_q + EW'(adv);
    ep_en    = adv;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     cur_ep_q <= '0;
    else if (ep_en) cur_ep_q <= cur_ep_n;
  end

  fsb_store_queue #(
    .DEPTH(DEPTH), .AW(AW), .DW(DW), .EW(EW)
  ) u_queue (
    .clk      (clk),
    .rst_n    (rst_n),
    .push     (push),
    .push_addr(st_addr),
    .push_data(st_data),
    .push_nt  (st_nt),
    .push_ep  (cur_ep_n),
    .pop      (pop),
    .pop_idx  (sel_idx),
    .cnt      (buf_cnt),
    .cnt_nx   (buf_cnt_nx),
    .addr_q   (addr_q),
    .data_q   (data_q),
    .nt_q     (nt_q),
    .ep_q     (ep_q)
  );

  fsb_commit_pick #(
    .DEPTH(DEPTH), .EW(EW)
  ) u_pick (
    .clk    (clk),
    .rst_n  (rst_n),
    .cnt    (buf_cnt),
    .nt_q   (nt_q),
    .ep_q   (ep_q),
    .ack    (cm_ack),
    .offer  (cm_valid),
    .sel_idx(sel_idx)
  );

  fsb_load_gate #(
    .MAX_LOADS(MAX_LOADS)
  ) u_gate (
    .clk           (clk),
    .rst_n         (rst_n),
    .ld_req        (ld_req),
    .ld_done       (ld_done),
    .lf_now        (lf_now),
    .ff_now        (ff_now),
    .buf_empty     (buf_cnt == '0),
    .buf_empty_nx  (buf_cnt_nx == '0),
    .ld_gnt        (ld_gnt),
    .ld_outstanding(ld_outstanding)
  );

  assign cm_addr = addr_q[sel_idx];
  assign cm_data = data_q[sel_idx];

endmodule

// File: rtl/fsb_checks.sv
module fsb_checks #(
  parameter int DEPTH = 8,
  parameter int AW    = 16,
  parameter int DW    = 32,
  parameter int CW    = 4,
  parameter int EW    = 4,
  parameter int LW    = 3
) (
  input logic          clk,
  input logic          rst_n,
  input logic          fence_valid,
  input logic          ld_req,
  input logic          ld_gnt,
  input logic          ld_done,
  input logic [LW-1:0] ld_outstanding,
  input logic          cm_valid,
  input logic          cm_ack,
  input logic [AW-1:0] cm_addr,
  input logic [DW-1:0] cm_data,
  input logic [CW-1:0] buf_cnt,
  input logic [EW-1:0] head_ep,
  input logic [EW-1:0] sel_ep
);
  logic past_ok;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) past_ok <= 1'b0;
    else        past_ok <= 1'b1;
  end

  assert_offer_stable_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (cm_valid && !cm_ack) |=> (cm_valid && $stable(cm_data) && $stable(cm_addr)));

  assert_no_overflow_R10: assert property (@(posedge clk) disable iff (!rst_n)
    buf_cnt <= CW'(DEPTH));

  assert_oldest_epoch_R4: assert property (@(posedge clk) disable iff (!rst_n)
    cm_valid |-> (sel_ep == head_ep));

  assert_block_has_cause_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_req && !ld_gnt && !fence_valid) |-> (ld_outstanding != '0 || cm_valid));

  assert_load_count_R11: assert property (@(posedge clk) disable iff (!rst_n)
    past_ok |-> (ld_outstanding == $past(ld_outstanding + LW'(ld_req && ld_gnt)
                                         - LW'(ld_done && ld_outstanding != '0))));

endmodule

bind fence_store_buffer fsb_checks #(
  .DEPTH(DEPTH), .AW(AW), .DW(DW), .CW(CW), .EW(EW), .LW(LW)
) u_fsb_checks (
  .clk           (clk),
  .rst_n         (rst_n),
  .fence_valid   (fence_valid),
  .ld_req        (ld_req),
  .ld_gnt        (ld_gnt),
  .ld_done       (ld_done),
  .ld_outstanding(ld_outstanding),
  .cm_valid      (cm_valid),
  .cm_ack        (cm_ack),
  .cm_addr       (cm_addr),
  .cm_data       (cm_data),
  .buf_cnt       (buf_cnt),
  .head_ep       (ep_q[0]),
  .sel_ep        (ep_q[sel_idx])
);

// File: tb/tb_fence_store_buffer.sv
module tb_fence_store_buffer;
  localparam int CLK_PERIOD = 10;
  localparam int DEPTH      = 8;
  localparam int AW         = 16;
  localparam int DW         = 32;
  localparam int MAX_LOADS  = 7;
  localparam int LW         = $clog2(MAX_LOADS+1);

  logic          clk, rst_n;
  logic          st_valid, st_ready, st_nt;
  logic [AW-1:0] st_addr;
  logic [DW-1:0] st_data;
  logic          fence_valid;
  logic [1:0]    fence_kind;
  logic          ld_req, ld_gnt, ld_done;
  logic [LW-1:0] ld_outstanding;
  logic          cm_valid, cm_ack;
  logic [AW-1:0] cm_addr;
  logic [DW-1:0] cm_data;

  int checks = 0;
  int errors = 0;
  bit done_flag = 0;

  fence_store_buffer #(
    .DEPTH(DEPTH), .AW(AW), .DW(DW), .MAX_LOADS(MAX_LOADS)
  ) dut (
    .clk(clk), .rst_n(rst_n),
    .st_valid(st_valid), .st_ready(st_ready), .st_addr(st_addr),
    .st_data(st_data), .st_nt(st_nt),
    .fence_valid(fence_valid), .fence_kind(fence_kind),
    .ld_req(ld_req), .ld_gnt(ld_gnt), .ld_done(ld_done),
    .ld_outstanding(ld_outstanding),
    .cm_valid(cm_valid), .cm_addr(cm_addr), .cm_data(cm_data), .cm_ack(cm_ack)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic push(input logic [DW-1:0] d, input logic nt);
    @(negedge clk);
    st_valid = 1'b1; st_data = d; st_addr = AW'(d) + 16'h100; st_nt = nt;
    @(posedge clk); #1;
    st_valid = 1'b0; st_nt = 1'b0;
  endtask

  task automatic fence(input logic [1:0] kind);
    @(negedge clk);
    fence_valid = 1'b1; fence_kind = kind;
    @(posedge clk); #1;
    fence_valid = 1'b0; fence_kind = 2'b00;
  endtask

  task automatic take(input logic [DW-1:0] exp, input string req);
    @(negedge clk); #1;
    chk(req, {31'd0, cm_valid}, 32'd1);
    chk(req, cm_data, exp);
    cm_ack = 1'b1;
    @(posedge clk); #1;
    cm_ack = 1'b0;
  endtask

  task automatic grant_load(input string req);
    @(negedge clk);
    ld_req = 1'b1; #1;
    chk(req, {31'd0, ld_gnt}, 32'd1);
    @(posedge clk); #1;
    ld_req = 1'b0;
  endtask

  task automatic finish_load;
    @(negedge clk);
    ld_done = 1'b1;
    @(posedge clk); #1;
    ld_done = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done_flag) begin
      checks++; errors++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; st_valid = 1'b0; st_nt = 1'b0; st_addr = '0; st_data = '0;
    fence_valid = 1'b0; fence_kind = 2'b00; ld_req = 1'b0; ld_done = 1'b0; cm_ack = 1'b0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;

    // R1: reset state
    @(negedge clk); #1;
    chk("R1 st_ready", {31'd0, st_ready}, 32'd1);
    chk("R1 cm_valid", {31'd0, cm_valid}, 32'd0);
    chk("R1 ld_outstanding", 32'(ld_outstanding), 32'd0);
    ld_req = 1'b1; #1;
    chk("R1 gate open", {31'd0, ld_gnt}, 32'd1);
    ld_req = 1'b0;

    // R2: normal stores in one epoch leave in order
    for (int i = 1; i <= 4; i++) push(DW'(i), 1'b0);
    for (int i = 1; i <= 4; i++) take(DW'(i), "R2 fifo order");
    @(negedge clk); #1;
    chk("R2 drained", {31'd0, cm_valid}, 32'd0);

    // R3: non-temporal store overtakes an older normal store (head 10 already offered)
    push(32'd10, 1'b0); push(32'd11, 1'b0); push(32'd12, 1'b1);
    take(32'd10, "R3 held head");
    take(32'd12, "R3 nt overtakes");
    take(32'd11, "R3 older normal last");

    // R4: store fence keeps the later NT store behind, stalls nothing
    push(32'd20, 1'b0); push(32'd21, 1'b0);
    fence(2'b01);
    @(negedge clk); #1;
    chk("R4 st_ready after fence", {31'd0, st_ready}, 32'd1);
    push(32'd22, 1'b1);
    grant_load("R4 load not stalled");
    finish_load;
    take(32'd20, "R4 order");
    take(32'd21, "R4 fenced older");
    take(32'd22, "R4 nt behind fence");

    // R5 / R11: load fence waits for outstanding loads only
    grant_load("R11 grant a");
    grant_load("R11 grant b");
    @(negedge clk); #1;
    chk("R11 count two", 32'(ld_outstanding), 32'd2);
    fence_valid = 1'b1; fence_kind = 2'b10; ld_req = 1'b1; #1;
    chk("R5 blocked same cycle", {31'd0, ld_gnt}, 32'd0);
    @(posedge clk); #1;
    fence_valid = 1'b0; fence_kind = 2'b00;
    push(32'd30, 1'b0);
    take(32'd30, "R5 stores unaffected");
    @(negedge clk); #1;
    chk("R5 still blocked", {31'd0, ld_gnt}, 32'd0);
    finish_load;
    @(negedge clk); #1;
    chk("R5 blocked one left", {31'd0, ld_gnt}, 32'd0);
    chk("R11 count one", 32'(ld_outstanding), 32'd1);
    finish_load;
    @(negedge clk); #1;
    chk("R11 count zero", 32'(ld_outstanding), 32'd0);
    chk("R5 released", {31'd0, ld_gnt}, 32'd1);
    @(posedge clk); #1;
    ld_req = 1'b0;
    finish_load;

    // R6: full fence orders stores and blocks loads until empty
    push(32'd40, 1'b0); push(32'd41, 1'b0);
    fence(2'b11);
    push(32'd42, 1'b1);
    @(negedge clk);
    ld_req = 1'b1; #1;
    chk("R6 load blocked", {31'd0, ld_gnt}, 32'd0);
    take(32'd40, "R6 order");
    take(32'd41, "R6 fenced older");
    @(negedge clk); #1;
    chk("R6 blocked one left", {31'd0, ld_gnt}, 32'd0);
    take(32'd42, "R6 nt behind fence");
    @(negedge clk); #1;
    chk("R6 released when empty", {31'd0, ld_gnt}, 32'd1);
    @(posedge clk); #1;
    ld_req = 1'b0;
    finish_load;

    // R7: store fence + load fence is not a full fence
    push(32'd50, 1'b0);
    fence(2'b01);
    fence(2'b10);
    @(negedge clk);
    ld_req = 1'b1; #1;
    chk("R7 stores buffered", {31'd0, cm_valid}, 32'd1);
    chk("R7 load still issues", {31'd0, ld_gnt}, 32'd1);
    @(posedge clk); #1;
    ld_req = 1'b0;
    finish_load;
    take(32'd50, "R7 drain");

    // R8: full fence on an empty buffer costs nothing
    @(negedge clk);
    fence_valid = 1'b1; fence_kind = 2'b11; ld_req = 1'b1; #1;
    chk("R8 gate open", {31'd0, ld_gnt}, 32'd1);
    @(posedge clk); #1;
    fence_valid = 1'b0; fence_kind = 2'b00; ld_req = 1'b0;
    @(negedge clk); #1;
    chk("R8 no hold after", {31'd0, ld_gnt | ~ld_req}, 32'd1);
    ld_req = 1'b1; #1;
    chk("R8 gate open next", {31'd0, ld_gnt}, 32'd1);
    ld_req = 1'b0;
    finish_load;

    // R10: back-pressure when full
    for (int i = 0; i < DEPTH; i++) push(DW'(70 + i), 1'b0);
    @(negedge clk); #1;
    chk("R10 st_ready low", {31'd0, st_ready}, 32'd0);
    push(32'd99, 1'b0);
    for (int i = 0; i < DEPTH; i++) take(DW'(70 + i), "R10 contents");
    @(negedge clk); #1;
    chk("R10 full store dropped", {31'd0, cm_valid}, 32'd0);

    // R9: held offer survives a younger NT store
    push(32'd80, 1'b0);
    @(negedge clk); #1;
    push(32'd81, 1'b1);
    @(negedge clk); #1;
    chk("R9 offer stable", cm_data, 32'd80);
    chk("R9 addr stable", 32'(cm_addr), 32'h150);
    take(32'd80, "R9 held store");
    take(32'd81, "R9 next");

    done_flag = 1;
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule